// File: doc/BRIEF.md
# Serial-Loaded Bank Control Registers

This block keeps the configuration state of a cartridge memory mapper. Software cannot write these registers in parallel. It fills each one through a single-bit serial port, one bit per bus write. Every accepted write without the abort bit moves data bit 0 into a five-bit accumulator, least significant bit first. The fifth such write commits the accumulated value to one of four targets. Address bits 14:13 of that fifth write choose the target.

A write with data bit 7 set cancels a partial load. It also forces the two code-paging flags to their power-on values. A short lockout follows every accepted write. It drops writes that arrive too soon, such as the second write of a read-modify-write instruction. The decoded fields drive the address translation logic that sits next to this block.

Top module: `serial_bank_regs`

## Requirements
- R1: After a synchronous active-low reset, the outputs read as follows: tile_mode_o=0, code_span_o=1, code_fix_o=1, mirror_o=0, tile_bank0_o=0, tile_bank1_o=1, wram_off_o=0 and code_bank_o=0. The shift count and the lockout count are both zero.
- R2: Each accepted write with data bit 7 clear shifts data bit 0 into the accumulator, least significant bit first. After five such writes, bit i of the committed value equals data bit 0 of write i+1.
- R3: Address bits 14:13 of the fifth write select the target, and all other address bits are ignored. The encodings are 0 = control, 1 = tile bank 0, 2 = tile bank 1 and 3 = code bank.
- R4: A commit to the control target loads four fields from the value: bit 4 into tile_mode_o, bit 3 into code_span_o, bit 2 into code_fix_o and bits 1:0 into mirror_o.
- R5: A commit to tile bank 0 or to tile bank 1 loads all five bits into tile_bank0_o or tile_bank1_o.
- R6: A commit to the code target loads value bit 4 into wram_off_o and bits 3:0 into code_bank_o.
- R7: An accepted write with data bit 7 set returns the shift count to zero and sets code_span_o and code_fix_o to 1. It leaves every other output unchanged.
- R8: Every accepted write, including an abort write, loads the lockout counter with 2. A write that arrives while the counter is nonzero is ignored completely.
- R9: The lockout counter decreases by one only in a cycle with tick high. While tick is low it holds its value.
- R10: A write that coincides with a tick is judged against the counter value from before that tick's decrement.
- R11: No output changes on the first four writes of a sequence. No output changes on an ignored write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Per-cycle enable that ages the lockout counter |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 16 | Write address; only bits 14:13 are decoded |
| wr_data | input | 8 | Write data; bit 7 aborts, bit 0 is the serial bit |
| tile_mode_o | output | 1 | Tile banking mode flag |
| code_span_o | output | 1 | Code paging size flag (0 = 32K, 1 = 16K) |
| code_fix_o | output | 1 | Code paging fixed-slot select |
| mirror_o | output | 2 | Nametable mirroring selection |
| tile_bank0_o | output | 5 | First tile bank number |
| tile_bank1_o | output | 5 | Second tile bank number |
| wram_off_o | output | 1 | Work RAM disable flag |
| code_bank_o | output | 4 | Code bank number |

## Verification
The outputs never show the shift count or the accumulator directly, so internal errors appear only at commit time. A miscounted shift position makes a commit happen one write early or one write late, and the wrong field takes the value. A wrong lockout count lets a write that should be dropped get through, or drops a write that should be taken. That shifts every later bit of the sequence by one place, so the error shows in the committed value at the end of the sequence. The bench gives each dropped write a bit value that differs from the bit value the accepted write carries, so any timing slip produces a value different from the expected one.

// File: rtl/sbr_pkg.sv
// Shared types and constants for the serial bank register block.
// Assumes a five-bit serial register and an eight-bit data bus.
package sbr_pkg;
    localparam int SR_W   = 5;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_TILE0 = 2'd1,
        SEL_TILE1 = 2'd2,
        SEL_CODE  = 2'd3
    } sbr_sel_e;

    typedef struct packed {
        logic       tile_mode;
        logic       code_span;
        logic       code_fix;
        logic [1:0] mirror;
        logic [4:0] tile_bank0;
        logic [4:0] tile_bank1;
        logic       wram_off;
        logic [3:0] code_bank;
    } sbr_cfg_t;
endpackage

// File: rtl/sbr_lockout.sv
// Write lockout timer. A request is accepted only while the counter is zero.
// An accepted request reloads the counter, and each tick ages it by one.
// Assumes that the request and the tick are sampled in the same cycle, and
// that the acceptance test sees the counter value from before the decrement.
module sbr_lockout #(
    parameter int LOCK_INIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wr_req,
    output logic accept
);
    localparam int LOCK_W = $clog2(LOCK_INIT + 1);

    logic [LOCK_W-1:0] lock_q;

    assign accept = wr_req && (lock_q == '0);

    // Counter: reload on accept, otherwise count down on tick until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= '0;
        else if (accept)
            lock_q <= LOCK_W'(LOCK_INIT);
        else if (tick && lock_q != '0)
            lock_q <= lock_q - 1'b1;
    end

    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> lock_q == LOCK_W'(LOCK_INIT));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_req) |=> $stable(lock_q));
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_req && lock_q != '0) |=> lock_q == $past(lock_q) - 1'b1);
    a_r10_late_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && tick && lock_q == LOCK_W'(1)) |=> lock_q == '0);
endmodule

// File: rtl/sbr_shifter.sv
// Serial accumulator. Each accepted non-abort write shifts a bit in at the
// top, and the fifth one raises a single-cycle commit that carries the full
// value. An accepted abort write clears the position count. Assumes that
// accept is already qualified by the lockout.
module sbr_shifter #(
    parameter int SR_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            abort,
    input  logic            bit_in,
    output logic            commit,
    output logic [SR_W-1:0] commit_val
);
    localparam int CNT_W = $clog2(SR_W + 1);

    logic [SR_W-1:0]  sr_q;
    logic [SR_W-1:0]  sr_next;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign sr_next    = {bit_in, sr_q[SR_W-1:1]};
    assign last       = (cnt_q == CNT_W'(SR_W - 1));
    assign commit     = accept && !abort && last;
    assign commit_val = sr_next;

    // Position and data update on accepted writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            if (abort) begin
                cnt_q <= '0;
            end else begin
                sr_q  <= sr_next;
                cnt_q <= last ? '0 : cnt_q + 1'b1;
            end
        end
    end

    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(SR_W));
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !abort && !last) |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && abort) |=> cnt_q == '0);
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(cnt_q) && $stable(sr_q)));
endmodule

// File: rtl/sbr_regfile.sv
// Target registers. A commit loads the register that sel picks, and a force
// sets the two code-paging flags. Assumes that commit and force never occur
// in the same cycle.
module sbr_regfile
    import sbr_pkg::*;
#(
    parameter int SR_W    = 5,
    parameter int N_TILE  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  logic            force_page,
    input  logic [1:0]      sel,
    input  logic [SR_W-1:0] val,
    output sbr_cfg_t        cfg
);
    logic       tile_mode_q, code_span_q, code_fix_q, wram_off_q;
    logic [1:0] mirror_q;
    logic [3:0] code_bank_q;
    logic [4:0] tile_bank [N_TILE];

    // Control and code registers; the force takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tile_mode_q <= 1'b0;
            code_span_q <= 1'b1;
            code_fix_q  <= 1'b1;
            mirror_q    <= 2'd0;
            wram_off_q  <= 1'b0;
            code_bank_q <= 4'd0;
        end else if (force_page) begin
            code_span_q <= 1'b1;
            code_fix_q  <= 1'b1;
        end else if (commit) begin
            case (sbr_sel_e'(sel))
                SEL_CTRL: begin
                    tile_mode_q <= val[4];
                    code_span_q <= val[3];
                    code_fix_q  <= val[2];
                    mirror_q    <= val[1:0];
                end
                SEL_CODE: begin
                    wram_off_q  <= val[4];
                    code_bank_q <= val[3:0];
                end
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < N_TILE; i++) begin : g_tile
        logic [4:0] bank_q;
        // Tile bank i: loaded whole when its select code commits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q <= 5'(i);
            else if (commit && sel == 2'(int'(SEL_TILE0) + i))
                bank_q <= val[4:0];
        end
        assign tile_bank[i] = bank_q;
    end

    // Pack the fields for the top level.
    always_comb begin
        cfg            = '0;
        cfg.tile_mode  = tile_mode_q;
        cfg.code_span  = code_span_q;
        cfg.code_fix   = code_fix_q;
        cfg.mirror     = mirror_q;
        cfg.tile_bank0 = tile_bank[0];
        cfg.tile_bank1 = tile_bank[1];
        cfg.wram_off   = wram_off_q;
        cfg.code_bank  = code_bank_q;
    end

    a_r7_force_paging: assert property (@(posedge clk) disable iff (!rst_n)
        force_page |=> (cfg.code_span && cfg.code_fix));
    a_r7_force_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        force_page |=> ($stable(cfg.tile_bank0) && $stable(cfg.mirror) && $stable(cfg.code_bank)));
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !force_page) |=> $stable(cfg));
    a_r5_tile1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sel == 2'd2) |=> cfg.tile_bank1 == $past(val[4:0]));
    a_r0_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && force_page));
endmodule

// File: rtl/serial_bank_regs.sv
// Top level of the serial-loaded bank control registers. It connects the
// lockout timer, the serial accumulator and the register file. Assumes one
// cycle of wr_en per bus write and a synchronous active-low reset.
module serial_bank_regs
    import sbr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SEL_LO    = 13,
    parameter int LOCK_INIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tile_mode_o,
    output logic              code_span_o,
    output logic              code_fix_o,
    output logic [1:0]        mirror_o,
    output logic [4:0]        tile_bank0_o,
    output logic [4:0]        tile_bank1_o,
    output logic              wram_off_o,
    output logic [3:0]        code_bank_o
);
    logic            accept, abort, commit;
    logic [SR_W-1:0] commit_val;
    logic [1:0]      sel;
    sbr_cfg_t        cfg;
    logic            sbr_unused;

    assign abort      = wr_data[DATA_W-1];
    assign sel        = wr_addr[SEL_LO+1:SEL_LO];
    assign sbr_unused = ^{wr_addr, wr_data};

    sbr_lockout #(.LOCK_INIT(LOCK_INIT)) u_lock (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_req(wr_en), .accept(accept)
    );

    sbr_shifter #(.SR_W(SR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .accept(accept), .abort(abort),
        .bit_in(wr_data[0]), .commit(commit), .commit_val(commit_val)
    );

    sbr_regfile #(.SR_W(SR_W), .N_TILE(2)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .force_page(accept && abort),
        .sel(sel), .val(commit_val), .cfg(cfg)
    );

    assign tile_mode_o  = cfg.tile_mode;
    assign code_span_o  = cfg.code_span;
    assign code_fix_o   = cfg.code_fix;
    assign mirror_o     = cfg.mirror;
    assign tile_bank0_o = cfg.tile_bank0;
    assign tile_bank1_o = cfg.tile_bank1;
    assign wram_off_o   = cfg.wram_off;
    assign code_bank_o  = cfg.code_bank;

    a_r8_no_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !accept);
endmodule

// File: tb/serial_bank_regs_bench.sv
module serial_bank_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tile_mode_o, code_span_o, code_fix_o, wram_off_o;
    logic [1:0]  mirror_o;
    logic [4:0]  tile_bank0_o, tile_bank1_o;
    logic [3:0]  code_bank_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_bank_regs u_serial_bank_regs (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .tile_mode_o(tile_mode_o), .code_span_o(code_span_o),
        .code_fix_o(code_fix_o), .mirror_o(mirror_o),
        .tile_bank0_o(tile_bank0_o), .tile_bank1_o(tile_bank1_o),
        .wram_off_o(wram_off_o), .code_bank_o(code_bank_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // One bus write: strobe for exactly one clock edge.
    task automatic put(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // A write spaced so that the lockout has expired (tick held high).
    task automatic send(input logic [15:0] a, input logic [7:0] d);
        put(a, d);
        idle(1);
    endtask

    task automatic load_reg(input logic [15:0] a, input logic [4:0] v);
        for (int i = 0; i < 5; i++) send(a, {7'b0, v[i]});
    endtask

    task automatic t_reset;
        chk("R1 tile_mode", tile_mode_o, 0);
        chk("R1 code_span", code_span_o, 1);
        chk("R1 code_fix", code_fix_o, 1);
        chk("R1 mirror", mirror_o, 0);
        chk("R1 tile_bank0", tile_bank0_o, 0);
        chk("R1 tile_bank1", tile_bank1_o, 1);
        chk("R1 wram_off", wram_off_o, 0);
        chk("R1 code_bank", code_bank_o, 0);
    endtask

    task automatic t_ctrl;
        logic [4:0] v = 5'b10110;
        for (int i = 0; i < 4; i++) send(16'h8000, {7'b0, v[i]});
        chk("R11 no early commit span", code_span_o, 1);
        chk("R11 no early commit mirror", mirror_o, 0);
        send(16'h8000, {7'b0, v[4]});
        chk("R4 tile_mode", tile_mode_o, 1);
        chk("R4 code_span", code_span_o, 0);
        chk("R4 code_fix", code_fix_o, 1);
        chk("R2 R4 mirror", mirror_o, 2);
    endtask

    task automatic t_banks;
        load_reg(16'hBFFF, 5'h15);
        chk("R3 R5 tile_bank0 via 0xBFFF", tile_bank0_o, 5'h15);
        load_reg(16'h5234, 5'h0A);
        chk("R3 R5 tile_bank1", tile_bank1_o, 5'h0A);
        chk("R5 tile_bank0 untouched", tile_bank0_o, 5'h15);
        load_reg(16'hE000, 5'h1B);
        chk("R6 wram_off", wram_off_o, 1);
        chk("R6 code_bank", code_bank_o, 4'hB);
        chk("R3 ctrl untouched", mirror_o, 2);
    endtask

    task automatic t_abort;
        send(16'hA000, 8'h01);
        send(16'hA000, 8'h01);
        send(16'h8000, 8'h81);
        chk("R7 span forced", code_span_o, 1);
        chk("R7 fix forced", code_fix_o, 1);
        chk("R7 tile_mode kept", tile_mode_o, 1);
        chk("R7 mirror kept", mirror_o, 2);
        chk("R7 bank0 kept", tile_bank0_o, 5'h15);
        load_reg(16'hA000, 5'h03);
        chk("R7 count cleared", tile_bank0_o, 5'h03);
    endtask

    task automatic t_lockout;
        logic [4:0] v = 5'h19;
        load_reg(16'h8000, 5'b00101);
        chk("R4 span cleared", code_span_o, 0);
        for (int i = 0; i < 5; i++) begin
            put(16'hC000, {7'b0, v[i]});
            put(16'h8000, (i % 2 == 0) ? 8'h80 : {7'b0, ~v[i]});
            idle(1);
        end
        chk("R8 bank1 from accepted only", tile_bank1_o, 5'h19);
        chk("R8 locked abort ignored", code_span_o, 0);
        chk("R8 ctrl mirror", mirror_o, 1);
    endtask

    task automatic t_same_cycle;
        logic [4:0] v = 5'b01101;
        for (int i = 0; i < 5; i++) begin
            put(16'hA000, {7'b0, v[i]});
            put(16'hA000, {7'b0, ~v[i]});
        end
        idle(1);
        chk("R10 alternate writes dropped", tile_bank0_o, 5'h0D);
    endtask

    task automatic t_tick_gate;
        tick = 1'b0;
        put(16'hE000, 8'h01);
        for (int i = 0; i < 4; i++) begin
            idle(4);
            put(16'hE000, 8'h01);
        end
        chk("R9 nothing committed", code_bank_o, 4'hB);
        tick = 1'b1;
        idle(2);
        for (int i = 0; i < 4; i++) send(16'hE000, 8'h00);
        chk("R9 code_bank", code_bank_o, 1);
        chk("R9 wram_off", wram_off_o, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_ctrl;
        t_banks;
        t_abort;
        t_lockout;
        t_same_cycle;
        t_tick_gate;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule